// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the effective address of an operand or branch target for a small processor with 8-bit data and 16-bit addresses. It takes a mode code, the address field of the current instruction, the instruction length in bytes, the address of that instruction and a pointer register value. It returns a 16-bit address together with a one-cycle completion strobe.

Most modes finish one clock after the request. These are the relocatable 256-byte page, the absolute address, short and long PC-relative branches, and pointer-register indirection. The memory-indirect mode fetches a 16-bit pointer through a synchronous byte-wide read port before it completes. While that fetch runs, the block ignores further requests.

All address arithmetic wraps modulo 2^16. The reset is asynchronous and active-low, and the block releases it synchronously through a two-stage synchronizer.

Top module: `ea_gen`

## Requirements
- R1: While reset is held, and after it is released with no request, `done`, `busy` and `mem_rd_en` are low and `ea` is 0.
- R2: Mode code 0 (page mode) gives `ea = {page_base, field[7:0]}`; `field[15:8]` has no effect. `done` is high in the cycle after the accepting clock edge.
- R3: Mode code 1 (absolute) gives `ea = field`, with the same one-cycle timing as R2.
- R4: Mode code 2 (short relative) gives `ea = pc + ilen + sign_extend(field[7:0])` mod 2^16; `field[15:8]` has no effect.
- R5: Mode code 3 (long relative) gives `ea = pc + ilen + field` mod 2^16, with `field` taken as a 16-bit two's complement value.
- R6: In both relative modes, a displacement of zero yields `pc + ilen`. A displacement equal to minus `ilen` yields `pc` itself.
- R7: Mode code 4 (pointer register) gives `ea = ptr_reg`.
- R8: Mode code 5 (memory indirect) reads byte address `field` in the first cycle after acceptance and `field + 1` (mod 2^16) in the second. The low byte comes first. Read data returns one cycle after each read. `done` rises in the fourth cycle after acceptance with `ea = {byte at field+1, byte at field}`.
- R9: `busy` is high from the cycle after a memory-indirect acceptance until the cycle before `done`. A request presented while `busy` is high is ignored: it produces no `done` and does not change `ea`.
- R10: `done` lasts one cycle per completed request, and `ea` keeps its value in every cycle in which `done` is low.
- R11: The unused mode codes 6 and 7 complete in one cycle with `ea = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request; accepted on a clock edge when `busy` is low |
| mode | input | 3 | Addressing mode code (0 to 7) |
| field | input | 16 | Address field of the instruction |
| ilen | input | 3 | Length of the current instruction in bytes |
| pc | input | 16 | Address of the current instruction |
| page_base | input | 8 | High byte of the relocatable page |
| ptr_reg | input | 16 | Pointer register value |
| mem_rd_en | output | 1 | Read request to the synchronous memory port |
| mem_addr | output | 16 | Read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the read |
| busy | output | 1 | A pointer fetch is in progress |
| done | output | 1 | One-cycle strobe: `ea` is valid |
| ea | output | 16 | Effective address |

## Verification
A corrupted fetch state shows up at the memory port within one cycle as a missing read, an extra read or a wrong read address. It also shifts the `done` pulse away from the fourth cycle after acceptance. A wrong captured low byte, or a byte-order swap, shows in `ea` on the cycle of `done`. An error in the sign extension or the PC advance shows in `ea` one cycle after the request. The sweeps across all short displacements and across wrap-around program counters expose it on the first such request.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [2:0] {
    AM_PAGE    = 3'd0,
    AM_ABS     = 3'd1,
    AM_REL_S   = 3'd2,
    AM_REL_L   = 3'd3,
    AM_PTR_REG = 3'd4,
    AM_PTR_MEM = 3'd5
  } amode_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_RD_LO,
    FS_RD_HI,
    FS_WAIT
  } fstate_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_gen_pkg::*;
#(
  parameter int AW    = 16,
  parameter int OFF_W = 8,
  parameter int SD_W  = 8,
  parameter int LEN_W = 3
) (
  input  logic [2:0]          mode,
  input  logic [AW-1:0]       field,
  input  logic [LEN_W-1:0]    ilen,
  input  logic [AW-1:0]       pc,
  input  logic [AW-OFF_W-1:0] page_base,
  input  logic [AW-1:0]       ptr_reg,
  output logic [AW-1:0]       addr
);
  localparam int PB_W = AW - OFF_W;

  logic [AW-1:0] next_pc;
  logic [AW-1:0] disp_short;

  always_comb begin
    next_pc    = pc + AW'(ilen);
    disp_short = {{(AW-SD_W){field[SD_W-1]}}, field[SD_W-1:0]};
    case (mode)
      AM_PAGE:    addr = {page_base[PB_W-1:0], field[OFF_W-1:0]};
      AM_ABS:     addr = field;
      AM_REL_S:   addr = next_pc + disp_short;
      AM_REL_L:   addr = next_pc + field;
      AM_PTR_REG: addr = ptr_reg;
      default:    addr = '0;
    endcase
  end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch
  import ea_gen_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ptr_addr,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          busy,
  output logic          fin,
  output logic [AW-1:0] fin_addr
);
  fstate_e       state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] lo_q, lo_d;
  logic          addr_en, lo_en;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    lo_d      = lo_q;
    addr_en   = 1'b0;
    lo_en     = 1'b0;
    mem_rd_en = 1'b0;
    fin       = 1'b0;
    fin_addr  = {mem_rd_data, lo_q};
    case (state_q)
      FS_IDLE: if (start) begin
        state_d = FS_RD_LO;
        addr_d  = ptr_addr;
        addr_en = 1'b1;
      end
      FS_RD_LO: begin
        mem_rd_en = 1'b1;
        state_d   = FS_RD_HI;
        addr_d    = addr_q + AW'(1);
        addr_en   = 1'b1;
      end
      FS_RD_HI: begin
        mem_rd_en = 1'b1;
        lo_d      = mem_rd_data;
        lo_en     = 1'b1;
        state_d   = FS_WAIT;
      end
      default: begin
        fin     = 1'b1;
        state_d = FS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q <= addr_d;
      if (lo_en)   lo_q   <= lo_d;
    end
  end

  assign mem_addr = addr_q;
  assign busy     = (state_q != FS_IDLE);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int OFF_W = 8,
  parameter int SD_W  = 8,
  parameter int LEN_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          mode,
  input  logic [AW-1:0]       field,
  input  logic [LEN_W-1:0]    ilen,
  input  logic [AW-1:0]       pc,
  input  logic [AW-OFF_W-1:0] page_base,
  input  logic [AW-1:0]       ptr_reg,
  output logic                mem_rd_en,
  output logic [AW-1:0]       mem_addr,
  input  logic [DW-1:0]       mem_rd_data,
  output logic                busy,
  output logic                done,
  output logic [AW-1:0]       ea
);
  logic [1:0]    rst_sync_q;
  logic          rst_ok;
  logic          accept, is_mem, fetch_busy, fetch_fin;
  logic [AW-1:0] calc_addr, fetch_addr;
  logic [AW-1:0] ea_q, ea_d;
  logic          done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  assign accept = req_valid && !fetch_busy;
  assign is_mem = (mode == AM_PTR_MEM);

  ea_calc #(.AW(AW), .OFF_W(OFF_W), .SD_W(SD_W), .LEN_W(LEN_W)) u_calc (
    .mode(mode), .field(field), .ilen(ilen), .pc(pc),
    .page_base(page_base), .ptr_reg(ptr_reg), .addr(calc_addr)
  );

  ea_ptr_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_ok), .start(accept && is_mem), .ptr_addr(field),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .busy(fetch_busy), .fin(fetch_fin), .fin_addr(fetch_addr)
  );

  always_comb begin
    ea_d   = ea_q;
    done_d = 1'b0;
    if (fetch_fin) begin
      ea_d   = fetch_addr;
      done_d = 1'b1;
    end else if (accept && !is_mem) begin
      ea_d   = calc_addr;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ea_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (done_d) ea_q <= ea_d;
    end
  end

  assign ea   = ea_q;
  assign done = done_q;
  assign busy = fetch_busy;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        req_valid,
  input logic [2:0]  mode,
  input logic [15:0] field,
  input logic [7:0]  page_base,
  input logic        busy,
  input logic        done,
  input logic [15:0] ea,
  input logic        mem_rd_en,
  input logic [15:0] mem_addr
);
  logic acc;
  assign acc = req_valid && !busy;

  assert_idle_port_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_rd_en |-> busy);

  assert_page_addr_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc && mode == 3'd0) |=> (done && ea == {$past(page_base), $past(field[7:0])}));

  assert_ptr_lo_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc && mode == 3'd5) |=> (mem_rd_en && mem_addr == $past(field)));

  assert_ptr_hi_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(mem_rd_en) |=> (mem_rd_en && mem_addr == $past(mem_addr) + 16'd1));

  assert_no_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    busy |-> !done);

  assert_ea_hold_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !done |-> $stable(ea));
endmodule

bind ea_gen ea_gen_chk u_chk (
  .clk(clk), .rst_ok(rst_ok), .req_valid(req_valid), .mode(mode),
  .field(field), .page_base(page_base), .busy(busy), .done(done),
  .ea(ea), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr)
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  mode;
  logic [15:0] field, pc, ptr_reg, mem_addr, ea;
  logic [2:0]  ilen;
  logic [7:0]  page_base, mem_rd_data;
  logic        mem_rd_en, busy, done;
  int n_tot = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ea_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .field(field),
    .ilen(ilen), .pc(pc), .page_base(page_base), .ptr_reg(ptr_reg),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .ea(ea)
  );

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mbyte(mem_addr);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_simple(input logic [2:0] m, input logic [15:0] f, input logic [15:0] p,
                            input logic [2:0] il, input logic [7:0] pb, input logic [15:0] pr,
                            input logic [15:0] exp, input string tag);
    @(negedge clk);
    mode = m; field = f; pc = p; ilen = il; page_base = pb; ptr_reg = pr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done === 1'b1 && ea === exp, tag, ea, exp);
  endtask

  task automatic run_mem(input logic [15:0] f);
    logic [15:0] exp;
    exp = {mbyte(f + 16'd1), mbyte(f)};
    @(negedge clk);
    mode = 3'd5; field = f; req_valid = 1'b1;
    @(negedge clk);
    chk(busy && mem_rd_en && mem_addr === f && !done, "R8 low read", mem_addr, f);
    mode = 3'd1; field = 16'h1234;
    @(negedge clk);
    chk(busy && mem_rd_en && mem_addr === f + 16'd1 && !done, "R8 high read", mem_addr, f + 16'd1);
    @(negedge clk);
    chk(busy && !mem_rd_en && !done, "R9 busy no done", {14'd0, busy, done}, 16'h0002);
    req_valid = 1'b0;
    @(negedge clk);
    chk(done === 1'b1 && !busy && ea === exp, "R8 pointer value", ea, exp);
    @(negedge clk);
    chk(!done && ea === exp, "R10 pulse and hold", ea, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_tot++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; mode = '0; field = '0; pc = '0; ilen = '0;
    page_base = '0; ptr_reg = '0;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_rd_en && ea === 16'h0, "R1 in reset", ea, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !busy && !mem_rd_en && ea === 16'h0, "R1 after release", ea, 16'h0);

    for (int pb = 0; pb < 256; pb += 15)
      for (int o = 0; o < 256; o += 17)
        run_simple(3'd0, {8'hA5, 8'(o)}, 16'h0, 3'd2, 8'(pb), 16'h0, {8'(pb), 8'(o)}, "R2 page");

    for (int i = 0; i < 17; i++)
      run_simple(3'd1, 16'(i * 16'h1111) ^ 16'h0F0F, 16'h0, 3'd1, 8'h0, 16'h0,
                 16'(i * 16'h1111) ^ 16'h0F0F, "R3 absolute");

    for (int pi = 0; pi < 3; pi++) begin
      logic [15:0] pcv;
      pcv = (pi == 0) ? 16'h0000 : (pi == 1) ? 16'h8000 : 16'hFFFE;
      for (int il = 1; il <= 4; il++)
        for (int d = 0; d < 256; d++)
          run_simple(3'd2, {8'hC3, 8'(d)}, pcv, 3'(il), 8'h0, 16'h0,
                     pcv + 16'(il) + {{8{d[7]}}, 8'(d)}, "R4 short rel");
    end

    for (int k = 0; k < 8; k++) begin
      logic [15:0] dv, pcv;
      dv  = (k == 0) ? 16'h7FFF : (k == 1) ? 16'h8000 : (k == 2) ? 16'hFFFF : 16'(k * 16'h2345);
      pcv = 16'(k * 16'h3001) + 16'hF000;
      run_simple(3'd3, dv, pcv, 3'd3, 8'h0, 16'h0, pcv + 16'd3 + dv, "R5 long rel");
    end

    run_simple(3'd2, 16'h0000, 16'h4000, 3'd2, 8'h0, 16'h0, 16'h4002, "R6 short zero");
    run_simple(3'd2, 16'h00F9, 16'h4000, 3'd2, 8'h0, 16'h0, 16'h3FFB, "R6 short back seven");
    run_simple(3'd2, 16'h00FE, 16'h4000, 3'd2, 8'h0, 16'h0, 16'h4000, "R6 short self loop");
    run_simple(3'd3, 16'h0000, 16'hFFFD, 3'd3, 8'h0, 16'h0, 16'h0000, "R6 long zero wrap");
    run_simple(3'd3, 16'hFFFD, 16'h1230, 3'd3, 8'h0, 16'h0, 16'h1230, "R6 long self loop");

    for (int i = 0; i < 8; i++)
      run_simple(3'd4, 16'h5555, 16'h0, 3'd1, 8'h0, 16'(i * 16'h2493) + 16'h0101,
                 16'(i * 16'h2493) + 16'h0101, "R7 pointer reg");

    run_mem(16'h0000);
    run_mem(16'h1234);
    run_mem(16'h80FF);
    run_mem(16'hFFFF);

    run_simple(3'd1, 16'hBEEF, 16'h0, 3'd1, 8'h0, 16'h0, 16'hBEEF, "R3 before R11");
    run_simple(3'd6, 16'hBEEF, 16'h0, 3'd1, 8'h0, 16'hFFFF, 16'h0000, "R11 code six");
    run_simple(3'd1, 16'hCAFE, 16'h0, 3'd1, 8'h0, 16'h0, 16'hCAFE, "R3 before R11");
    run_simple(3'd7, 16'hCAFE, 16'h0, 3'd1, 8'h0, 16'hFFFF, 16'h0000, "R11 code seven");
    repeat (2) @(negedge clk);
    chk(!done && ea === 16'h0000, "R10 idle hold", ea, 16'h0000);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule